// File: doc/BRIEF.md
# Windowed Watchdog Timer

This block is a window watchdog: a down-counter that software has to reload inside a time window. If the count runs out, the block requests a system reset. If software reloads too early, it also requests a reset. The counter is 7 bits wide and steps down once per prescaled tick. The tick period is a base divider (parameter `TICK_BASE`, default 4096 clocks) multiplied by 1, 2, 4 or 8, as chosen by a 2-bit select.

Software reaches the block through a small register port with four addresses:

| Address | Register | Contents |
|---|---|---|
| 0 | control | counter in bits [6:0], run bit in bit 7 |
| 1 | config | window value in bits [6:0], tick scaling select in bits [8:7], warning-interrupt enable in bit 9 |
| 2 | status | sticky early-warning flag in bit 0 |
| 3 | unused | reads zero |

A write to address 0 reloads the counter and restarts the tick divider. If bit 7 of that write is 1, it also starts the watchdog. When the counter steps down to 0x40, the warning flag is set, which gives software one last tick period to reload. The reset request is a one-cycle pulse. Distributing that reset is left to the surrounding chip.

Top module: `window_watchdog`

## Requirements
- R1: After `rst_n` is asserted, the block reads back as follows: address 0 gives 0x07F, address 1 gives 0x07F, address 2 gives 0. Both `rst_req` and `ew_irq` are low.
- R2: The run bit (address 0, bit 7) is set by writing 1. A later write of 0 leaves it set. Only `rst_n` clears it.
- R3: While the watchdog is stopped, the counter holds its value. A counter write while stopped loads the value and never requests a reset, whatever the window value is.
- R4: While running, the counter drops by one every `TICK_BASE << sel` clocks, where `sel` is address 1 bits [8:7]. Timing is counted from the last write to address 0.
- R5: While running, when the counter steps from 0x40 to 0x3F, `rst_req` pulses high for exactly one cycle. The pulse is registered and appears in the cycle after the clock edge at which the step happens.
- R6: A write to address 0 while running, with the current counter strictly above the window value (address 1 bits [6:0]), makes `rst_req` pulse for one cycle after that write edge. If the counter is equal to or below the window value, there is no pulse.
- R7: When the counter steps down to 0x40, the status flag (address 2, bit 0) is set. `ew_irq` equals that flag ANDed with the interrupt enable (address 1, bit 9).
- R8: Writing address 2 with bit 0 = 0 clears the flag. Writing bit 0 = 1 leaves it unchanged.
- R9: Bits that carry no field read as zero and ignore writes. Those bits are address 0 bits [9:8], address 2 bits [9:1], and all of address 3.
- R10: A write to address 0 in the same cycle as a tick takes priority over that tick. The written value is loaded, and the tick causes no decrement, no flag set and no reset pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register address (0 control, 1 config, 2 status) |
| wdata | input | 10 | Write data |
| rdata | output | 10 | Read data for `addr`, combinational |
| rst_req | output | 1 | One-cycle system reset request |
| ew_irq | output | 1 | Early-warning interrupt |

## Verification
A software reload of the counter and a prescaler tick can land on the same clock edge. That collision is provoked twice:
- once at the tick that would move the counter to 0x40;
- once at the tick that would underflow it to 0x3F.

In each case the bench times the write to arrive exactly one tick period after the previous reload. It then judges that the written value was loaded, that no flag was set and that no reset pulse occurred. It also checks that the next decrement arrives one full period after the colliding write.

// File: rtl/window_watchdog.sv
module window_watchdog #(
  parameter int TICK_BASE = 4096,
  parameter int CNT_W     = 7,
  parameter int PSC_W     = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic [1:0]               addr,
  input  logic [CNT_W+PSC_W:0]     wdata,
  output logic [CNT_W+PSC_W:0]     rdata,
  output logic                     rst_req,
  output logic                     ew_irq
);
  localparam int REG_W = CNT_W + PSC_W + 1;
  localparam int PRE_W = $clog2(TICK_BASE) + (1 << PSC_W);
  localparam logic [CNT_W-1:0] THRESH = CNT_W'(1) << (CNT_W - 1);
  localparam logic [CNT_W-1:0] EARLY  = THRESH + CNT_W'(1);

  logic             en, ie, flag, rst_q;
  logic [CNT_W-1:0] cnt, win;
  logic [PSC_W-1:0] psc;
  logic [PRE_W-1:0] pre, period_m1;

  wire wr_ctrl = wr_en && (addr == 2'd0);
  wire wr_cfg  = wr_en && (addr == 2'd1);
  wire wr_stat = wr_en && (addr == 2'd2);

  assign period_m1 = (PRE_W'(TICK_BASE) << psc) - PRE_W'(1);
  wire tick = en && (pre >= period_m1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en    <= 1'b0;
      cnt   <= '1;
      win   <= '1;
      psc   <= '0;
      ie    <= 1'b0;
      flag  <= 1'b0;
      rst_q <= 1'b0;
      pre   <= '0;
    end else begin
      rst_q <= 1'b0;
      if (wr_ctrl) begin
        cnt <= wdata[CNT_W-1:0];
        pre <= '0;
        if (wdata[CNT_W]) en <= 1'b1;
        if (en && (cnt > win)) rst_q <= 1'b1;
      end else if (en) begin
        pre <= tick ? '0 : pre + PRE_W'(1);
        if (tick) begin
          cnt <= cnt - CNT_W'(1);
          if (cnt == THRESH) rst_q <= 1'b1;
          if (cnt == EARLY)  flag  <= 1'b1;
        end
      end
      if (wr_cfg) begin
        win <= wdata[CNT_W-1:0];
        psc <= wdata[CNT_W+PSC_W-1:CNT_W];
        ie  <= wdata[CNT_W+PSC_W];
      end
      if (wr_stat && !wdata[0]) flag <= 1'b0;
    end
  end

  always_comb begin
    case (addr)
      2'd0:    rdata = REG_W'({en, cnt});
      2'd1:    rdata = {ie, psc, win};
      2'd2:    rdata = REG_W'(flag);
      default: rdata = '0;
    endcase
  end

  assign rst_req = rst_q;
  assign ew_irq  = flag & ie;

  AST_EN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    en |=> en); // R2
  AST_HOLD_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !wr_ctrl) |=> $stable(cnt)); // R3
  AST_UNDERFLOW_RST: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(cnt[CNT_W-1]) && !$past(wr_ctrl)) |-> rst_req); // R5
  AST_RST_ONLY_RUNNING: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |-> $past(en)); // R6
  AST_FLAG_AT_THRESH: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag) |-> (cnt == THRESH)); // R7
endmodule

// File: tb/sim_window_watchdog.sv
module sim_window_watchdog;
  localparam int CLK_P = 10;
  localparam int BASE  = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [9:0] wdata = '0;
  logic [9:0] rdata;
  logic       rst_req, ew_irq;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int exp_q[$];

  window_watchdog #(.TICK_BASE(BASE)) u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .rst_req(rst_req), .ew_irq(ew_irq));

  always #(CLK_P/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [9:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(logic [1:0] a, output logic [9:0] v);
    addr = a; #1; v = rdata;
  endtask

  task automatic expect_rst(int at);
    exp_q.push_back(at);
  endtask

  task automatic wait_n(int n);
    repeat (n) @(negedge clk);
  endtask

  // monitor: pops expected reset pulses and compares their cycle
  initial begin
    forever begin
      @(negedge clk); #2;
      if (rst_req === 1'b1) begin
        if (exp_q.size() == 0) check("R5/R6 unexpected rst_req", cyc, 0);
        else check("R5/R6 rst_req cycle", cyc, exp_q.pop_front());
      end
    end
  end

  initial begin
    #(CLK_P * 150000);
    check("watchdog expired", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [9:0] v;
    int k;
    wait_n(3);
    rst_n = 1'b1;
    wait_n(1);
    // R1 reset state
    rd(2'd0, v); check("R1 ctrl", v, 10'h07F);
    rd(2'd1, v); check("R1 cfg", v, 10'h07F);
    rd(2'd2, v); check("R1 status", v, 0);
    check("R1 rst_req", rst_req, 0);
    check("R1 ew_irq", ew_irq, 0);

    // R3 stopped: load with tiny window, no reset, no counting
    wr(2'd1, 10'h010);
    wr(2'd0, 10'h050);
    wait_n(20);
    rd(2'd0, v); check("R3 hold while stopped", v, 10'h050);

    // R4/R5/R7 run down to underflow, sel=0, irq enabled
    wr(2'd1, 10'h27F);
    wr(2'd0, 10'h0C5); k = cyc;
    expect_rst(k + 24);
    wait_n(10); rd(2'd0, v); check("R4 count after 10 clocks", v, 10'h0C3);
    wait_n(9);  rd(2'd2, v); check("R7 flag before 0x40", v, 0);
    wait_n(1);  rd(2'd2, v); check("R7 flag at 0x40", v, 1);
    check("R7 ew_irq enabled", ew_irq, 1);
    wait_n(6);

    // R2 writing run bit 0 keeps it running
    wr(2'd0, 10'h000);
    rd(2'd0, v); check("R2 run bit sticky", v, 10'h080);

    // R8 flag clearing
    wr(2'd2, 10'h001);
    rd(2'd2, v); check("R8 write 1 keeps flag", v, 1);
    wr(2'd2, 10'h000);
    rd(2'd2, v); check("R8 write 0 clears flag", v, 0);
    check("R8 ew_irq low", ew_irq, 0);

    // R6 window boundary and R4 with sel=1
    wr(2'd1, 10'h07F);
    wr(2'd0, 10'h0D0);
    wr(2'd1, 10'h0D0);
    wr(2'd0, 10'h050); k = cyc;
    wait_n(7); rd(2'd0, v); check("R4 sel1 before period", v, 10'h0D0);
    wait_n(1); rd(2'd0, v); check("R4 sel1 at period", v, 10'h0CF);
    wr(2'd1, 10'h0FF);
    wr(2'd0, 10'h051);
    wr(2'd1, 10'h0D0);
    expect_rst(cyc + 1);
    wr(2'd0, 10'h051);
    rd(2'd0, v); check("R6 write loaded", v, 10'h0D1);
    wait_n(2);

    // R10 write colliding with tick
    wr(2'd1, 10'h27F);
    wr(2'd2, 10'h000);
    wr(2'd0, 10'h041);
    wait_n(3);
    wr(2'd0, 10'h07F);
    rd(2'd0, v); check("R10 write wins over tick to 0x40", v, 10'h0FF);
    rd(2'd2, v); check("R10 no flag from superseded tick", v, 0);
    wr(2'd0, 10'h040);
    wait_n(3);
    wr(2'd0, 10'h07F);
    rd(2'd0, v); check("R10 write wins over underflow", v, 10'h0FF);
    wait_n(4);
    rd(2'd0, v); check("R10 divider restarts after write", v, 10'h0FE);

    // R7 masked interrupt, flag still set, then underflow
    wr(2'd1, 10'h07F);
    wr(2'd0, 10'h041); k = cyc;
    expect_rst(k + 8);
    wait_n(4);
    rd(2'd2, v); check("R7 flag with irq masked", v, 1);
    check("R7 ew_irq masked", ew_irq, 0);
    wait_n(5);

    // R9 reserved bits
    wr(2'd0, 10'h330);
    rd(2'd0, v); check("R9 ctrl reserved bits", v, 10'h0B0);
    wr(2'd2, 10'h3FE);
    rd(2'd2, v); check("R9 status reserved/clear", v, 0);
    wr(2'd3, 10'h3FF);
    rd(2'd3, v); check("R9 address 3 reads zero", v, 0);

    // R2/R1 only the hardware reset clears the run bit
    rst_n = 1'b0;
    wait_n(2);
    rd(2'd0, v); check("R2 reset clears run bit", v, 10'h07F);
    rd(2'd1, v); check("R1 cfg after reset", v, 10'h07F);
    rst_n = 1'b1;
    wait_n(2);

    check("R5/R6 pending pulses", exp_q.size(), 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule